// File: doc/BRIEF.md
# PHY Reset and Receive-PLL Lock Sequencer

This block brings a serial PHY out of reset after its PLL clock has been enabled. On a start pulse it drives a short, fixed programme through the command side of a PHY register-access handshake master. First it selects the PHY's clock-reset register and writes its reset bit. It then waits a programmable settling time and reads the lane status register, repeating the pair until the receive PLL reports lock or the poll budget is used up.

Commands go out as a held valid with an operation code and a 16-bit word. The same word carries the register address for an address-capture command and the data for a write. The master accepts a command with `cmd_ready` and later returns one response with a timeout flag and read data. The reset write is marked as needing no acknowledge, because the PHY cannot answer while it resets. The sequencer does not wait for a response to that write.

The block reports the end of the programme with a one-cycle done pulse. A fail flag and a cause flag stay valid until the next start. The start input must not be pulsed until the PHY PLL clock has been running for about 100 to 200 microseconds.

Top module: `phy_pll_bringup`

## Requirements
- R1: After reset, `done`, `fail`, `fail_pll` and `cmd_valid` are all 0.
- R2: A start pulse in idle makes the first command an address capture (`cmd_op` = 0) with word `RST_REG` (default 0x7F3F) and `cmd_noack` = 0.
- R3: While `cmd_valid` is 1 and `cmd_ready` is 0, `cmd_valid`, `cmd_op`, `cmd_wdata` and `cmd_noack` hold their values on the next cycle.
- R4: After the reset-address response arrives without timeout, the next command is a write (`cmd_op` = 1) of `RST_VAL` (default 0x0001) with `cmd_noack` = 1. It is the only command ever marked no-acknowledge, and the sequencer moves on after it is accepted without waiting for any response.
- R5: The next command goes out exactly `DELAY_CYC` cycles after the reset write is accepted: `cmd_valid` is high for the first time `DELAY_CYC` clock edges after the accepting edge.
- R6: Each poll is an address capture of `STAT_REG` (default 0x2003), then, once that response is in without timeout, a read (`cmd_op` = 2) with `cmd_noack` = 0.
- R7: A read response with bit `LOCK_BIT` (default 1) set ends the programme with success: `done` pulses and `fail` = 0. All other bits of the read word are ignored.
- R8: At most `MAX_POLLS` (default 10) reads are issued. If none of them shows lock, the programme ends with `done`, `fail` = 1 and `fail_pll` = 1, and no further command follows.
- R9: A response with `rsp_timeout` = 1 to any address or read command ends the programme at once with `done`, `fail` = 1 and `fail_pll` = 0, and no further command follows.
- R10: `done` is high for exactly one cycle per run. `fail` and `fail_pll` hold their final values until the next accepted start, which clears them.
- R11: A start pulse while a programme is running has no effect on the command stream or the outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin the programme (only acted on in idle) |
| done | output | 1 | One-cycle end-of-programme pulse |
| fail | output | 1 | Programme ended in error |
| fail_pll | output | 1 | Error cause: lock never seen within the poll budget |
| cmd_valid | output | 1 | Command request to the handshake master |
| cmd_ready | input | 1 | Master accepts the command on this edge |
| cmd_op | output | 2 | 0 address capture, 1 write, 2 read |
| cmd_wdata | output | DATA_W | Register address or write data |
| cmd_noack | output | 1 | Master must not wait for a PHY acknowledge |
| rsp_valid | input | 1 | Response for the last acknowledged command |
| rsp_timeout | input | 1 | The PHY handshake timed out |
| rsp_rdata | input | DATA_W | Read data for a read command |

## Verification
On every cycle, the assertions check the command hold rule while the master stalls, the single-cycle done pulse, and that the no-acknowledge marker appears only on a write. They also check that the poll counter stays inside its budget, that the settling counter only steps downward, and that fail can rise only together with done. The order and contents of the command stream, the exact settling gap after the reset write, lock on the first, a middle or the last poll, budget exhaustion, a timeout at different points, and a start while busy can only be shown by the bench's scenarios.

// File: rtl/physeq_pkg.sv
package physeq_pkg;

  typedef enum logic [1:0] {
    OP_ADDR  = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2
  } phy_op_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RADDR,
    ST_RADDR_W,
    ST_RWR,
    ST_DELAY,
    ST_PADDR,
    ST_PADDR_W,
    ST_PRD,
    ST_PRD_W
  } seq_state_e;

endpackage

// File: rtl/physeq_delay.sv
module physeq_delay #(
  parameter int CYC = 15000
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic fire
);
  localparam int CW = $clog2(CYC + 1);

  logic [CW-1:0] cnt;
  logic          run;

  always_ff @(posedge clk) begin
    if (rst) begin
      run <= 1'b0;
      cnt <= '0;
    end else if (load) begin
      run <= 1'b1;
      cnt <= CW'(CYC - 1);
    end else if (run) begin
      if (cnt == '0) run <= 1'b0;
      else           cnt <= cnt - 1'b1;
    end
  end

  assign fire = run && (cnt == '0);

  // R5: the settling counter only steps down by one while running
  a_r5_count_down: assert property (@(posedge clk) disable iff (rst)
    (run && !load && cnt != '0) |=> (run && cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/physeq_tries.sv
module physeq_tries #(
  parameter int MAX = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic last
);
  localparam int TW = $clog2(MAX + 1);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (inc)   cnt <= cnt + 1'b1;
  end

  assign last = (cnt == TW'(MAX - 1));

  // R8: the failed-poll count never reaches the budget
  a_r8_budget: assert property (@(posedge clk) disable iff (rst)
    cnt < TW'(MAX));

endmodule

// File: rtl/physeq_cmd.sv
module physeq_cmd
  import physeq_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue,
  input  phy_op_e           iss_op,
  input  logic [DATA_W-1:0] iss_data,
  input  logic              iss_noack,
  input  logic              ready,
  output logic              valid,
  output logic [1:0]        op,
  output logic [DATA_W-1:0] wdata,
  output logic              noack,
  output logic              accept
);
  assign accept = valid && ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      op    <= OP_ADDR;
      wdata <= '0;
      noack <= 1'b0;
    end else if (issue) begin
      valid <= 1'b1;
      op    <= iss_op;
      wdata <= iss_data;
      noack <= iss_noack;
    end else if (accept) begin
      valid <= 1'b0;
    end
  end

  // R3: a stalled command is held unchanged
  a_r3_cmd_hold: assert property (@(posedge clk) disable iff (rst)
    (valid && !ready) |=> (valid && $stable(op) && $stable(wdata) && $stable(noack)));

  // R4: only the write is sent without acknowledge
  a_r4_noack_write: assert property (@(posedge clk) disable iff (rst)
    (valid && noack) |-> (op == OP_WRITE));

endmodule

// File: rtl/phy_pll_bringup.sv
module phy_pll_bringup
  import physeq_pkg::*;
#(
  parameter int                DATA_W    = 16,
  parameter int                DELAY_CYC = 15000,
  parameter int                MAX_POLLS = 10,
  parameter int                LOCK_BIT  = 1,
  parameter logic [DATA_W-1:0] RST_REG   = 'h7F3F,
  parameter logic [DATA_W-1:0] RST_VAL   = 'h0001,
  parameter logic [DATA_W-1:0] STAT_REG  = 'h2003
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              done,
  output logic              fail,
  output logic              fail_pll,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [1:0]        cmd_op,
  output logic [DATA_W-1:0] cmd_wdata,
  output logic              cmd_noack,
  input  logic              rsp_valid,
  input  logic              rsp_timeout,
  input  logic [DATA_W-1:0] rsp_rdata
);
  localparam logic [DATA_W-1:0] LOCK_MASK = DATA_W'(1) << LOCK_BIT;

  seq_state_e        st, nxt;
  logic              issue, iss_noack, accept;
  phy_op_e           iss_op;
  logic [DATA_W-1:0] iss_data;
  logic              dly_load, fire;
  logic              tr_clr, tr_inc, tr_last;
  logic              fin, fin_fail, fin_pll;
  logic              locked;

  assign locked = (rsp_rdata & LOCK_MASK) != '0;

  physeq_cmd #(.DATA_W(DATA_W)) u_cmd (
    .clk(clk), .rst(rst), .issue(issue), .iss_op(iss_op), .iss_data(iss_data),
    .iss_noack(iss_noack), .ready(cmd_ready), .valid(cmd_valid), .op(cmd_op),
    .wdata(cmd_wdata), .noack(cmd_noack), .accept(accept)
  );

  physeq_delay #(.CYC(DELAY_CYC)) u_delay (
    .clk(clk), .rst(rst), .load(dly_load), .fire(fire)
  );

  physeq_tries #(.MAX(MAX_POLLS)) u_tries (
    .clk(clk), .rst(rst), .clr(tr_clr), .inc(tr_inc), .last(tr_last)
  );

  always_comb begin
    nxt       = st;
    issue     = 1'b0;
    iss_op    = OP_ADDR;
    iss_data  = '0;
    iss_noack = 1'b0;
    dly_load  = 1'b0;
    tr_clr    = 1'b0;
    tr_inc    = 1'b0;
    fin       = 1'b0;
    fin_fail  = 1'b0;
    fin_pll   = 1'b0;
    case (st)
      ST_IDLE: if (start) begin
        issue    = 1'b1;
        iss_data = RST_REG;
        tr_clr   = 1'b1;
        nxt      = ST_RADDR;
      end
      ST_RADDR: if (accept) nxt = ST_RADDR_W;
      ST_RADDR_W: if (rsp_valid) begin
        if (rsp_timeout) begin
          fin = 1'b1; fin_fail = 1'b1; nxt = ST_IDLE;
        end else begin
          issue     = 1'b1;
          iss_op    = OP_WRITE;
          iss_data  = RST_VAL;
          iss_noack = 1'b1;
          nxt       = ST_RWR;
        end
      end
      ST_RWR: if (accept) begin
        dly_load = 1'b1;
        nxt      = ST_DELAY;
      end
      ST_DELAY: if (fire) begin
        issue    = 1'b1;
        iss_data = STAT_REG;
        nxt      = ST_PADDR;
      end
      ST_PADDR: if (accept) nxt = ST_PADDR_W;
      ST_PADDR_W: if (rsp_valid) begin
        if (rsp_timeout) begin
          fin = 1'b1; fin_fail = 1'b1; nxt = ST_IDLE;
        end else begin
          issue  = 1'b1;
          iss_op = OP_READ;
          nxt    = ST_PRD;
        end
      end
      ST_PRD: if (accept) nxt = ST_PRD_W;
      ST_PRD_W: if (rsp_valid) begin
        if (rsp_timeout) begin
          fin = 1'b1; fin_fail = 1'b1; nxt = ST_IDLE;
        end else if (locked) begin
          fin = 1'b1; nxt = ST_IDLE;
        end else if (tr_last) begin
          fin = 1'b1; fin_fail = 1'b1; fin_pll = 1'b1; nxt = ST_IDLE;
        end else begin
          tr_inc   = 1'b1;
          dly_load = 1'b1;
          nxt      = ST_DELAY;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      done     <= 1'b0;
      fail     <= 1'b0;
      fail_pll <= 1'b0;
    end else begin
      st   <= nxt;
      done <= fin;
      if (st == ST_IDLE && start) begin
        fail     <= 1'b0;
        fail_pll <= 1'b0;
      end else if (fin) begin
        fail     <= fin_fail;
        fail_pll <= fin_pll;
      end
    end
  end

  // R10: done lasts a single cycle
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R10: fail only rises together with done
  a_r10_fail_with_done: assert property (@(posedge clk) disable iff (rst)
    $rose(fail) |-> done);

  // R9: nothing is requested when the programme has just ended
  a_r9_quiet_at_end: assert property (@(posedge clk) disable iff (rst)
    done |-> !cmd_valid);

endmodule

// File: tb/phy_pll_bringup_tb.sv
module phy_pll_bringup_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int D  = 8;
  localparam int MP = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic rst = 1'b1, start = 1'b0;
  logic done, fail, fail_pll, cmd_valid, cmd_noack;
  logic cmd_ready = 1'b0, rsp_valid = 1'b0, rsp_timeout = 1'b0;
  logic [1:0] cmd_op;
  logic [DW-1:0] cmd_wdata;
  logic [DW-1:0] rsp_rdata = '0;

  phy_pll_bringup #(.DATA_W(DW), .DELAY_CYC(D), .MAX_POLLS(MP)) u_dut (
    .clk(clk), .rst(rst), .start(start), .done(done), .fail(fail),
    .fail_pll(fail_pll), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_wdata(cmd_wdata), .cmd_noack(cmd_noack),
    .rsp_valid(rsp_valid), .rsp_timeout(rsp_timeout), .rsp_rdata(rsp_rdata)
  );

  int checks = 0, fails = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [18:0] sb[$];
  int ready_lat = 0, to_idx = -1, lock_rd = -1;
  int cmd_idx = 0, rd_no = 0, wait_n = 0, rsp_cnt = 0, t_wr = -1;
  logic rsp_to_n = 1'b0;
  logic [DW-1:0] rsp_d_n = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Responder and scoreboard monitor
  always @(negedge clk) begin
    rsp_valid = 1'b0;
    if (rsp_cnt > 0) begin
      rsp_cnt--;
      if (rsp_cnt == 0) begin
        rsp_valid   = 1'b1;
        rsp_timeout = rsp_to_n;
        rsp_rdata   = rsp_d_n;
      end
    end
    if (cmd_ready) cmd_ready = 1'b0;
    else if (cmd_valid && !rst) begin
      if (wait_n == 0 && t_wr >= 0 && cmd_op != 2'd1) begin
        chk(cyc - t_wr == D + 1, "R5", "settle gap", cyc - t_wr, D + 1);
        t_wr = -1;
      end
      if (wait_n < ready_lat) wait_n++;
      else begin
        wait_n = 0;
        cmd_ready = 1'b1;
        if (sb.size() == 0) chk(1'b0, "R8", "unexpected cmd", {cmd_op, cmd_noack, cmd_wdata}, 0);
        else begin
          logic [18:0] e;
          string rq;
          e = sb.pop_front();
          rq = (cmd_op == 2'd1) ? "R4" : (cmd_wdata == 16'h7F3F ? "R2" : "R6");
          chk({cmd_op, cmd_noack, cmd_wdata} == e, rq, "cmd", {cmd_op, cmd_noack, cmd_wdata}, e);
        end
        if (cmd_op == 2'd1) t_wr = cyc;
        if (!cmd_noack) begin
          rsp_cnt  = 2;
          rsp_to_n = (cmd_idx == to_idx);
          rsp_d_n  = (cmd_op == 2'd2) ? ((rd_no == lock_rd) ? 16'h0002 : 16'hFFFD) : 16'h0000;
          if (cmd_op == 2'd2) rd_no++;
        end
        cmd_idx++;
      end
    end
  end

  task automatic run_case(input int lat, input int to, input int lock, input bit poke);
    bit stop, e_fail, e_pll;
    int n;
    sb.delete();
    stop = 0;
    sb.push_back({2'd0, 1'b0, 16'h7F3F});
    if (to == 0) stop = 1;
    if (!stop) sb.push_back({2'd1, 1'b1, 16'h0001});
    for (int p = 0; p < MP && !stop; p++) begin
      sb.push_back({2'd0, 1'b0, 16'h2003});
      if (to == 2 + 2*p) stop = 1;
      else begin
        sb.push_back({2'd2, 1'b0, 16'h0000});
        if (to == 3 + 2*p || lock == p) stop = 1;
      end
    end
    e_fail = (to >= 0) || (lock < 0 || lock >= MP);
    e_pll  = (to < 0) && (lock < 0 || lock >= MP);
    ready_lat = lat; to_idx = to; lock_rd = lock;
    cmd_idx = 0; rd_no = 0; t_wr = -1; wait_n = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(fail == 1'b0 && fail_pll == 1'b0, "R10", "cleared by start", fail, 0);
    if (poke) begin
      repeat (5) @(negedge clk);
      start = 1'b1;                       // R11: ignored while running
      @(negedge clk) start = 1'b0;
    end
    n = 0;
    while (!done && n < 3000) begin @(negedge clk); n++; end
    chk(done == 1'b1, "R7", "done seen", done, 1);
    chk(fail == e_fail, e_pll ? "R8" : (to >= 0 ? "R9" : "R7"), "fail", fail, e_fail);
    chk(fail_pll == e_pll, e_pll ? "R8" : "R9", "fail_pll", fail_pll, e_pll);
    chk(sb.size() == 0, "R11", "cmds left", sb.size(), 0);
    @(negedge clk);
    chk(done == 1'b0, "R10", "done width", done, 0);
    repeat (6) @(negedge clk);
    chk(fail == e_fail && fail_pll == e_pll, "R10", "flags held", {fail, fail_pll}, {e_fail, e_pll});
    chk(cmd_valid == 1'b0, to >= 0 ? "R9" : "R8", "quiet after end", cmd_valid, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(done == 0 && fail == 0 && fail_pll == 0 && cmd_valid == 0, "R1", "reset state",
        {done, fail, fail_pll, cmd_valid}, 0);
    run_case(0, -1, 0, 0);   // R7 lock on first poll, R5 gap
    run_case(2, -1, 3, 1);   // R3 stalled master, R11 start while busy
    run_case(0, -1, -1, 0);  // R8 budget used up
    run_case(1, -1, 9, 0);   // R8 lock on last allowed poll
    run_case(0, 0, -1, 0);   // R9 timeout on reset address
    run_case(3, 2, -1, 0);   // R9 timeout on poll address
    run_case(0, 5, -1, 0);   // R9 timeout on second read
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule